// File: doc/BRIEF.md
# Processor Strobe Watchdog with Startup Window

This block watches a strobe toggled by software and raises a reset request when the strobe goes too long without changing level. Both rising and falling transitions count as a kick. The strobe is asynchronous to the block clock, so it passes through a synchronizer before edge detection. After every reset, and after every timeout, the first kick is allowed a much longer startup window instead of the normal timeout period.

A digital disable input stands in for the detection of an unconnected strobe pin. While it is high, the watchdog is held idle. A second input reports that the system reset is currently asserted; while it is high, the timer stays cleared and does not count. During margin testing the timer keeps running. Any timeout that happens in that time is held back and issued only after margin mode ends and a further unlock delay has passed. The request is a single-cycle pulse to the reset sequencer. All durations are parameters counted in clock ticks.

Top module: `strobe_watchdog`

## Requirements
- R1: The strobe passes through SYNC_STAGES (default 2) flip-flops before edge detection. A level change that is first sampled at clock edge m clears the timer at edge m+2, and the timer then enters the normal-period phase. Rising and falling changes have the same effect.
- R2: In the normal-period phase, with no further kick, the request pulse is high in the cycle that follows edge m+2+TIMEOUT_TICKS.
- R3: After the system reset input is released (first sampled low at edge 1), and with no kick, the request is high only after edge STARTUP_TICKS. No request appears after TIMEOUT_TICKS edges.
- R4: After a timeout the timer re-enters the startup phase. If no kick follows, the next request comes STARTUP_TICKS edges after the previous one.
- R5: While the system reset input is high, the request stays low and the timer is held at zero. A new startup window starts when the input is released.
- R6: While the disable input is high, no request is raised and strobe changes have no effect. When disable is released, a full startup window starts.
- R7: The timer keeps counting while the margin input is high, and the request stays low. A timeout that occurred during margin produces one request pulse after edge E+MARGIN_DLY, where E is the first edge at which margin is sampled low.
- R8: The request is low after the block reset `rst`, and it is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| strobe_i | input | 1 | Asynchronous software strobe; any level change is a kick |
| wd_off_i | input | 1 | High means the watchdog is disabled (strobe left unconnected) |
| sys_in_reset_i | input | 1 | High while the system reset is asserted |
| margin_i | input | 1 | High during margin testing; defers requests |
| wd_req_o | output | 1 | Single-cycle reset request pulse |

## Verification
A wrong count or phase inside the timer shows up at the request port as a pulse that comes early or late. The error reaches the port within one timeout or startup window of the fault. For this reason the bench checks the request on every cycle of each window, not only at the expected pulse. A lost deferred timeout shows up as a missing pulse MARGIN_DLY cycles after margin ends. A phase that is not cleared by reset or disable shows up as a pulse at the short period where the long window was due.

// File: rtl/swd_pkg.sv
package swd_pkg;

    typedef enum logic {
        PH_START = 1'b0,
        PH_RUN   = 1'b1
    } swd_phase_e;

    typedef struct packed {
        logic       fire;
        swd_phase_e phase;
    } swd_tmr_t;

    function automatic int unsigned swd_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned swd_width(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/swd_edge.sv
module swd_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic kick_o
);
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[SYNC_STAGES-1:0], strobe_i};
    end

    assign kick_o = pipe_q[SYNC_STAGES] ^ pipe_q[SYNC_STAGES-1];
endmodule

// File: rtl/swd_timer.sv
module swd_timer
    import swd_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1600,
    parameter int STARTUP_TICKS = 54000,
    localparam int CNT_W = swd_width(swd_max(TIMEOUT_TICKS, STARTUP_TICKS))
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_i,
    input  logic             kick_i,
    output swd_tmr_t         stat_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] RUN_LAST   = CNT_W'(TIMEOUT_TICKS - 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(STARTUP_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    swd_phase_e       phase_q;
    logic [CNT_W-1:0] last;
    logic             fire;

    always_comb begin
        last = (phase_q == PH_RUN) ? RUN_LAST : START_LAST;
        fire = !hold_i && !kick_i && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            cnt_q   <= '0;
            phase_q <= PH_START;
        end else if (kick_i) begin
            cnt_q   <= '0;
            phase_q <= PH_RUN;
        end else if (fire) begin
            cnt_q   <= '0;
            phase_q <= PH_START;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign stat_o = '{fire: fire, phase: phase_q};
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/swd_gate.sv
module swd_gate
    import swd_pkg::*;
#(
    parameter int MARGIN_DLY = 50,
    localparam int DLY_W = swd_width(MARGIN_DLY)
) (
    input  logic clk,
    input  logic rst,
    input  logic quiet_i,
    input  logic margin_i,
    input  logic fire_i,
    output logic req_o
);
    logic [DLY_W-1:0] unlock_q;
    logic             pend_q;
    logic             req_q;
    logic             held;

    assign held = margin_i || (unlock_q != '0);

    always_ff @(posedge clk) begin
        if (rst)                   unlock_q <= '0;
        else if (margin_i)         unlock_q <= DLY_W'(MARGIN_DLY);
        else if (unlock_q != '0)   unlock_q <= unlock_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || quiet_i) begin
            pend_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            pend_q <= held ? (pend_q || fire_i) : 1'b0;
            req_q  <= !held && (fire_i || pend_q);
        end
    end

    assign req_o = req_q;
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
    import swd_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1600,
    parameter int STARTUP_TICKS = 54000,
    parameter int MARGIN_DLY    = 50,
    parameter int SYNC_STAGES   = 2,
    localparam int CNT_W = swd_width(swd_max(TIMEOUT_TICKS, STARTUP_TICKS))
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic wd_off_i,
    input  logic sys_in_reset_i,
    input  logic margin_i,
    output logic wd_req_o
);
    logic             kick;
    logic             quiet;
    swd_tmr_t         tmr_stat;
    logic [CNT_W-1:0] tmr_cnt;

    assign quiet = wd_off_i || sys_in_reset_i;

    swd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .strobe_i(strobe_i), .kick_o(kick)
    );

    swd_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .STARTUP_TICKS(STARTUP_TICKS)) u_timer (
        .clk(clk), .rst(rst), .hold_i(quiet), .kick_i(kick),
        .stat_o(tmr_stat), .cnt_o(tmr_cnt)
    );

    swd_gate #(.MARGIN_DLY(MARGIN_DLY)) u_gate (
        .clk(clk), .rst(rst), .quiet_i(quiet), .margin_i(margin_i),
        .fire_i(tmr_stat.fire), .req_o(wd_req_o)
    );
endmodule

// File: rtl/strobe_watchdog_chk.sv
module strobe_watchdog_chk
    import swd_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1600,
    parameter int STARTUP_TICKS = 54000,
    localparam int CNT_W = swd_width(swd_max(TIMEOUT_TICKS, STARTUP_TICKS))
) (
    input logic             clk,
    input logic             rst,
    input logic             wd_off_i,
    input logic             sys_in_reset_i,
    input logic             margin_i,
    input logic             wd_req_o,
    input logic             kick,
    input swd_tmr_t         tmr_stat,
    input logic [CNT_W-1:0] tmr_cnt
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wd_req_o |=> !wd_req_o);

    a_r5_reset_holds: assert property (@(posedge clk) disable iff (rst)
        sys_in_reset_i |=> (!wd_req_o && tmr_cnt == '0));

    a_r6_disable_holds: assert property (@(posedge clk) disable iff (rst)
        wd_off_i |=> (!wd_req_o && tmr_cnt == '0));

    a_r7_margin_defers: assert property (@(posedge clk) disable iff (rst)
        margin_i |=> !wd_req_o);

    a_r1_kick_clears: assert property (@(posedge clk) disable iff (rst)
        (kick && !wd_off_i && !sys_in_reset_i) |=> (tmr_cnt == '0 && tmr_stat.phase == PH_RUN));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        int'(tmr_cnt) < swd_max(TIMEOUT_TICKS, STARTUP_TICKS));
endmodule

bind strobe_watchdog strobe_watchdog_chk #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS), .STARTUP_TICKS(STARTUP_TICKS)
) u_chk (
    .clk(clk), .rst(rst), .wd_off_i(wd_off_i), .sys_in_reset_i(sys_in_reset_i),
    .margin_i(margin_i), .wd_req_o(wd_req_o), .kick(kick),
    .tmr_stat(tmr_stat), .tmr_cnt(tmr_cnt)
);

// File: tb/sim_strobe_watchdog.sv
module sim_strobe_watchdog;
    localparam int TO  = 20;
    localparam int ST  = 60;
    localparam int DLY = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe = 1'b0;
    logic off = 1'b0;
    logic in_rst = 1'b1;
    logic margin = 1'b0;
    logic req;

    int n_chk = 0;
    int n_bad = 0;
    int n = 0;

    always #2 clk = ~clk;

    strobe_watchdog #(
        .TIMEOUT_TICKS(TO), .STARTUP_TICKS(ST), .MARGIN_DLY(DLY), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst(rst), .strobe_i(strobe), .wd_off_i(off),
        .sys_in_reset_i(in_rst), .margin_i(margin), .wd_req_o(req)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: req=%b expected %b", tag, n, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        n++;
    endtask

    task automatic enter_reset();
        in_rst = 1'b1;
        repeat (3) begin
            tick();
            chk("R5", req, 1'b0);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: done=0 expected 1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R8", req, 1'b0);

        // R3 then R4: startup window, then repeated startup windows
        n = 0; in_rst = 1'b0;
        for (int i = 0; i < 2 * ST + 3; i++) begin
            tick();
            chk((n <= ST) ? "R3" : "R4", req, (n == ST) || (n == 2 * ST));
        end

        // R1: rising kick first sampled at edge 10 -> request after 12+TO
        enter_reset();
        n = 0; in_rst = 1'b0;
        for (int i = 0; i < 32 + ST + 2; i++) begin
            tick();
            chk((n <= 32) ? "R1" : "R4", req, (n == 12 + TO) || (n == 12 + TO + ST));
            if (n == 9) strobe = 1'b1;
        end

        // R2: falling kick at edge 10, rising kick at edge 25 -> request after 27+TO
        enter_reset();
        n = 0; in_rst = 1'b0;
        for (int i = 0; i < 50; i++) begin
            tick();
            chk("R2", req, n == 27 + TO);
            if (n == 9)  strobe = 1'b0;
            if (n == 24) strobe = 1'b1;
        end

        // R5: reset in mid-count restarts a full startup window
        enter_reset();
        n = 0; in_rst = 1'b0;
        for (int i = 0; i < 30; i++) begin
            tick();
            chk("R5", req, 1'b0);
        end
        in_rst = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick();
            chk("R5", req, 1'b0);
        end
        n = 0; in_rst = 1'b0;
        for (int i = 0; i < ST + 2; i++) begin
            tick();
            chk("R5", req, n == ST);
        end

        // R6: disabled watchdog ignores time and strobe, then restarts
        enter_reset();
        off = 1'b1;
        n = 0; in_rst = 1'b0;
        for (int i = 0; i < 2 * ST + 5; i++) begin
            tick();
            chk("R6", req, 1'b0);
            if (n == 5) strobe = 1'b0;
        end
        n = 0; off = 1'b0;
        for (int i = 0; i < ST + 2; i++) begin
            tick();
            chk("R6", req, n == ST);
        end

        // R7: timeout during margin is deferred to E+DLY, counting continues
        enter_reset();
        margin = 1'b1;
        n = 0; in_rst = 1'b0;
        for (int i = 0; i < 2 * ST + 2; i++) begin
            tick();
            chk("R7", req, (n == ST + 11 + DLY) || (n == 2 * ST));
            if (n == ST + 10) margin = 1'b0;
        end

        summary();
        $finish;
    end
endmodule